// File: doc/BRIEF.md
# I/O Bus DMA Page Map Register File

This block holds the page-translation table that an I/O bus adapter uses to turn an 18-bit bus DMA address into a system memory address. It also holds the adapter's small set of control registers. A processor reaches all of it through a longword register port. Reads are combinational. Writes take effect on the next rising clock edge.

A separate combinational translate port looks up the map entry for a bus address. It returns the mapped system address and a valid flag. The bus address is split into a 9-bit page index and a 9-bit offset within a 512-byte page. The selected entry supplies a 21-bit page frame. An entry can also mark an odd-byte offset on a buffered data path, and such an entry moves the result up by one byte. Whether the resulting address names real memory is decided outside the block and arrives on one input bit.

Register offsets are counted in longwords (byte address divided by 4). Offset 0 is a fixed configuration code. Offsets 1 to 3 are data-path status registers. The map entries start at offset 0x200, with one entry per longword.

Top module: `busmap_regfile`

## Requirements
- R1: A synchronous active-low reset clears every map entry and all three status registers, so all of them read 0 afterwards.
- R2: A map entry write keeps bit 31 (valid), bit 25 (odd byte), bits 24:21 (data path) and bits 20:0 (page frame). The other bits are dropped, and a later read of that entry returns the masked value.
- R3: A map offset 0x200+k with k of 496 or more raises reg_nxm. A write there changes no entry.
- R4: Offset 0 reads 0x00000028 and ignores writes.
- R5: Offsets 1, 2 and 3 read only bits 31, 30, 29 and 0 of their register. Any write clears the register, so it reads 0 afterwards.
- R6: Every offset from 4 to 0x1FF raises reg_nxm and reads 0.
- R7: An access is accepted only when reg_size is 2 (longword; 0 is byte, 1 is word, 3 is quad) and reg_addr[1:0] is 0. Any other access leaves all state unchanged, reads 0 and does not raise reg_nxm. reg_rdata and reg_nxm are 0 whenever reg_req is low.
- R8: For a valid entry at page index bus_addr[17:9], xlat_addr equals the entry's frame shifted left by 9, plus bus_addr[8:0].
- R9: When the entry's data path is nonzero and its odd-byte bit is set, xlat_addr is one more than the R8 value. The sum wraps at 30 bits.
- R10: A page index of 496 or more, or an entry with the valid bit clear, gives xlat_ok = 0 and xlat_addr = 0.
- R11: xlat_ok is 1 only when the lookup succeeds and mem_exists is 1. When mem_exists is 0, xlat_addr still shows the mapped address.
- R12: In a cycle where an entry is written and also translated, the translation uses the old entry. The new entry is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access size: 0 byte, 1 word, 2 longword, 3 quad |
| reg_addr | input | 12 | Byte address within the adapter's register space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| reg_nxm | output | 1 | Nonexistent register response |
| bus_addr | input | 18 | Bus DMA address to translate |
| mem_exists | input | 1 | The mapped address is backed by memory |
| xlat_addr | output | 30 | Translated system address |
| xlat_ok | output | 1 | Translation succeeded and memory exists |

## Verification
The register port and the translate port run independently, so a map entry write can land in the same cycle as a lookup of that same page. The bench provokes this collision on purpose. It writes an entry while bus_addr points into that entry's page, and compares xlat_addr and xlat_ok against a model whose table has not yet taken the write (R12). One cycle later it compares against the updated table. A random phase repeats these collisions among rejected accesses, out-of-range offsets and index-boundary lookups, and compares every output on every cycle.

// File: rtl/busmap_pkg.sv
// busmap_pkg: types and constants shared by the page map register file.
// Assumes a 21-bit page frame and a 4-bit data-path number per entry.
package busmap_pkg;

    localparam int FRAME_W = 21;
    localparam int PATH_W  = 4;

    localparam logic [1:0]  SZ_LONG     = 2'd2;
    localparam logic [31:0] CFG_CODE    = 32'h0000_0028;
    localparam logic [31:0] CSR_RD_MASK = 32'hE000_0001;
    localparam logic [31:0] CSR_WR_MASK = 32'h0000_0000;

    typedef struct packed {
        logic               valid;
        logic               odd;
        logic [PATH_W-1:0]  path;
        logic [FRAME_W-1:0] frame;
    } map_ent_t;

    // Place an entry into its register image; unused bits are zero.
    function automatic logic [31:0] ent_to_word(input map_ent_t e);
        return {e.valid, 5'b0, e.odd, e.path, e.frame};
    endfunction

    // Extract the stored fields from a register image.
    function automatic map_ent_t word_to_ent(input logic [31:0] w);
        map_ent_t e;
        e.valid = w[31];
        e.odd   = w[25];
        e.path  = w[24:21];
        e.frame = w[20:0];
        return e;
    endfunction

endpackage

// File: rtl/busmap_decode.sv
// busmap_decode: splits a register access into its target.
// Assumes the byte address is REG_AW bits wide and that offsets are counted in longwords.
// Only aligned longword accesses reach any target. The others are dropped silently.
module busmap_decode
    import busmap_pkg::*;
#(
    parameter int REG_AW   = 12,
    parameter int MAP_BASE = 512,
    parameter int NUM_ENT  = 496,
    parameter int IDX_W    = 9,
    parameter int NUM_CSR  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [1:0]         size,
    input  logic [REG_AW-1:0]  addr,
    output logic               acc_ok,
    output logic               sel_cfg,
    output logic [NUM_CSR-1:0] sel_csr,
    output logic               sel_map,
    output logic [IDX_W-1:0]   map_idx,
    output logic               nxm
);
    localparam int OFS_W = REG_AW - 2;
    localparam logic [OFS_W-1:0] BASE_O = OFS_W'(MAP_BASE);
    localparam logic [OFS_W-1:0] NUM_O  = OFS_W'(NUM_ENT);
    localparam logic [OFS_W-1:0] CSR_HI = OFS_W'(NUM_CSR);

    logic [OFS_W-1:0] ofs;
    logic [OFS_W-1:0] rel;

    assign ofs    = addr[REG_AW-1:2];
    assign rel    = ofs - BASE_O;
    assign acc_ok = req && (size == SZ_LONG) && (addr[1:0] == 2'b00);

    // Pick the one target of an accepted access, or flag a nonexistent offset.
    always_comb begin
        sel_cfg = 1'b0;
        sel_csr = '0;
        sel_map = 1'b0;
        map_idx = '0;
        nxm     = 1'b0;
        if (acc_ok) begin
            if (ofs >= BASE_O) begin
                if (rel < NUM_O) begin
                    sel_map = 1'b1;
                    map_idx = rel[IDX_W-1:0];
                end else begin
                    nxm = 1'b1;
                end
            end else if (ofs == '0) begin
                sel_cfg = 1'b1;
            end else if (ofs <= CSR_HI) begin
                sel_csr[ofs - OFS_W'(1)] = 1'b1;
            end else begin
                nxm = 1'b1;
            end
        end
    end

    // R6: an access selects at most one target.
    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_cfg, sel_csr, sel_map, nxm}));

endmodule

// File: rtl/busmap_entries.sv
// busmap_entries: storage for the page map entries.
// It has one write port and two combinational read ports (register read and translate).
// An index at or above NUM_ENT reads as an empty entry.
module busmap_entries
    import busmap_pkg::*;
#(
    parameter int NUM_ENT = 496,
    parameter int IDX_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  map_ent_t         wr_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output map_ent_t         rd_ent,
    input  logic [IDX_W-1:0] xl_idx,
    output map_ent_t         xl_ent
);
    localparam logic [IDX_W-1:0] NUM_I = IDX_W'(NUM_ENT);

    map_ent_t map_q [NUM_ENT];

    // Clear every entry on reset, otherwise store one written entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) map_q[i] <= '0;
        end else if (wr_en && (wr_idx < NUM_I)) begin
            map_q[wr_idx] <= wr_ent;
        end
    end

    // Read ports, guarded against indices past the table.
    assign rd_ent = (rd_idx < NUM_I) ? map_q[rd_idx] : '0;
    assign xl_ent = (xl_idx < NUM_I) ? map_q[xl_idx] : '0;

    // R2: a written entry holds the written fields one cycle later.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx < NUM_I)) |=> (map_q[$past(wr_idx)] == $past(wr_ent)));

endmodule

// File: rtl/busmap_status.sv
// busmap_status: the buffered data-path status registers.
// Nothing in this block sets their bits. A write stores the data under a zero mask, which clears the register.
module busmap_status
    import busmap_pkg::*;
#(
    parameter int NUM_CSR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_CSR-1:0] sel,
    input  logic [31:0]        wdata,
    output logic [31:0]        rd_val
);
    logic [31:0] csr_q [NUM_CSR];

    for (genvar g = 0; g < NUM_CSR; g++) begin : g_csr
        // Hold one status register; a write applies the write mask.
        always_ff @(posedge clk) begin
            if (!rst_n)                 csr_q[g] <= '0;
            else if (wr_en && sel[g])   csr_q[g] <= wdata & CSR_WR_MASK;
        end

        // R5: the register reads zero after any write to it.
        p_clear_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && sel[g]) |=> (csr_q[g] == '0));
    end

    // Return the readable bits of the selected register.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_CSR; i++)
            if (sel[i]) rd_val = csr_q[i] & CSR_RD_MASK;
    end

endmodule

// File: rtl/busmap_xlate.sv
// busmap_xlate: combinational translation of a bus DMA address.
// Assumes pages of 2**PAGE_SHIFT bytes. It receives the entry for its page index from the storage.
// The result wraps at PA_W bits.
module busmap_xlate
    import busmap_pkg::*;
#(
    parameter int BUS_AW     = 18,
    parameter int PAGE_SHIFT = 9,
    parameter int NUM_ENT    = 496,
    parameter int IDX_W      = BUS_AW - PAGE_SHIFT,
    parameter int PA_W       = FRAME_W + PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              mem_exists,
    output logic [IDX_W-1:0]  idx,
    input  map_ent_t          ent,
    output logic [PA_W-1:0]   pa,
    output logic              ok
);
    localparam logic [IDX_W-1:0] NUM_I = IDX_W'(NUM_ENT);

    logic            hit;
    logic            bump;
    logic [PA_W-1:0] base;

    // Split the address, look up the entry and form the system address.
    always_comb begin
        idx  = bus_addr[BUS_AW-1:PAGE_SHIFT];
        hit  = (idx < NUM_I) && ent.valid;
        bump = ent.odd && (ent.path != '0);
        base = {ent.frame, bus_addr[PAGE_SHIFT-1:0]};
        pa   = hit ? (base + PA_W'(bump)) : '0;
        ok   = hit && mem_exists;
    end

    // R10: a page index past the table never translates.
    p_oob_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[BUS_AW-1:PAGE_SHIFT] >= NUM_I) |-> (!ok && pa == '0));

    // R11: success requires the memory-existence input.
    p_ok_needs_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> mem_exists);

endmodule

// File: rtl/busmap_regfile.sv
// busmap_regfile: the page map register file and its translate port.
// It joins the decoder, the entry storage, the status registers and the translator.
// Register reads are combinational. Writes land on the next rising edge.
module busmap_regfile
    import busmap_pkg::*;
#(
    parameter int REG_AW     = 12,
    parameter int BUS_AW     = 18,
    parameter int PAGE_SHIFT = 9,
    parameter int NUM_ENT    = 496,
    parameter int MAP_BASE   = 512,
    parameter int NUM_CSR    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_req,
    input  logic                          reg_we,
    input  logic [1:0]                    reg_size,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    output logic                          reg_nxm,
    input  logic [BUS_AW-1:0]             bus_addr,
    input  logic                          mem_exists,
    output logic [FRAME_W+PAGE_SHIFT-1:0] xlat_addr,
    output logic                          xlat_ok
);
    localparam int IDX_W = BUS_AW - PAGE_SHIFT;
    localparam int PA_W  = FRAME_W + PAGE_SHIFT;

    logic               acc_ok, sel_cfg, sel_map;
    logic [NUM_CSR-1:0] sel_csr;
    logic [IDX_W-1:0]   map_idx, xl_idx;
    logic [31:0]        csr_rd;
    map_ent_t           rd_ent, xl_ent;

    busmap_decode #(
        .REG_AW(REG_AW), .MAP_BASE(MAP_BASE), .NUM_ENT(NUM_ENT),
        .IDX_W(IDX_W), .NUM_CSR(NUM_CSR)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .req(reg_req), .size(reg_size), .addr(reg_addr),
        .acc_ok(acc_ok), .sel_cfg(sel_cfg), .sel_csr(sel_csr), .sel_map(sel_map),
        .map_idx(map_idx), .nxm(reg_nxm)
    );

    busmap_entries #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_entries (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we && sel_map), .wr_idx(map_idx), .wr_ent(word_to_ent(reg_wdata)),
        .rd_idx(map_idx), .rd_ent(rd_ent),
        .xl_idx(xl_idx), .xl_ent(xl_ent)
    );

    busmap_status #(.NUM_CSR(NUM_CSR)) u_status (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .sel(sel_csr),
        .wdata(reg_wdata), .rd_val(csr_rd)
    );

    busmap_xlate #(
        .BUS_AW(BUS_AW), .PAGE_SHIFT(PAGE_SHIFT), .NUM_ENT(NUM_ENT),
        .IDX_W(IDX_W), .PA_W(PA_W)
    ) u_xlate (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .mem_exists(mem_exists),
        .idx(xl_idx), .ent(xl_ent), .pa(xlat_addr), .ok(xlat_ok)
    );

    // Read data of the selected target; zero for rejected or nonexistent accesses.
    always_comb begin
        reg_rdata = '0;
        if (sel_cfg)      reg_rdata = CFG_CODE;
        else if (sel_map) reg_rdata = ent_to_word(rd_ent);
        else if (|sel_csr) reg_rdata = csr_rd;
    end

    // R4: the configuration offset always reads its code.
    p_cfg_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_size == SZ_LONG && reg_addr == '0) |-> (reg_rdata == CFG_CODE));

    // R7: a misaligned access is answered quietly.
    p_quiet_misaligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0 && !reg_nxm));

    // R7: the acceptance signal never rises without a request.
    p_no_accept_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_req |-> !acc_ok);

endmodule

// File: tb/busmap_regfile_tb.sv
`timescale 1ns/100ps
// busmap_regfile_tb_top: behavioural reference model and compare on every clock.
module busmap_regfile_tb_top;

    localparam int NENT = 496;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_size = 2'd2;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_nxm;
    logic [17:0] bus_addr = '0;
    logic        mem_exists = 1'b1;
    logic [29:0] xlat_addr;
    logic        xlat_ok;

    int errors = 0;
    int checks = 0;
    logic [31:0] mdl [NENT];

    always #2.5 clk = ~clk;

    busmap_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_size(reg_size), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_nxm(reg_nxm), .bus_addr(bus_addr),
        .mem_exists(mem_exists), .xlat_addr(xlat_addr), .xlat_ok(xlat_ok)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, update the model, pass the rising edge.
    task automatic cyc(input logic rq, input logic we, input logic [1:0] sz, input logic [11:0] ad,
                       input logic [31:0] wd, input logic [17:0] ba, input logic me, input string tag);
        logic        ok;
        int          ofs, idx, pg;
        logic [31:0] erd, ent;
        logic        enx, eok;
        logic [29:0] eaddr;
        reg_req = rq; reg_we = we; reg_size = sz; reg_addr = ad; reg_wdata = wd;
        bus_addr = ba; mem_exists = me;
        #1;
        ok = rq && sz == 2'd2 && ad[1:0] == 2'b00;
        ofs = int'(ad >> 2);
        erd = '0; enx = 1'b0;
        if (ok) begin
            if (ofs >= 512) begin
                idx = ofs - 512;
                if (idx >= NENT) enx = 1'b1; else erd = mdl[idx];
            end else if (ofs == 0) erd = 32'h28;
            else if (ofs <= 3) erd = 32'h0;
            else enx = 1'b1;
        end
        pg = int'(ba >> 9);
        eok = 1'b0; eaddr = '0;
        if (pg < NENT && mdl[pg][31]) begin
            ent = mdl[pg];
            eaddr = {ent[20:0], ba[8:0]} + ((ent[25] && ent[24:21] != 0) ? 30'd1 : 30'd0);
            eok = me;
        end
        chk(tag, "rdata", reg_rdata, erd);
        chk(tag, "nxm", {31'b0, reg_nxm}, {31'b0, enx});
        chk(tag, "xlat_addr", {2'b0, xlat_addr}, {2'b0, eaddr});
        chk(tag, "xlat_ok", {31'b0, xlat_ok}, {31'b0, eok});
        if (ok && we && ofs >= 512 && (ofs - 512) < NENT) mdl[ofs - 512] = wd & 32'h83FF_FFFF;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [11:0] map_a(input int k);
        return 12'((512 + k) * 4);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; reg_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NENT; i++) mdl[i] = '0;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NENT; i++) mdl[i] = '0;
        @(negedge clk);
        do_reset();
        // Fill some entries, then reset and confirm they are empty (R1)
        cyc(1, 1, 2, map_a(0),   32'h8000_0011, 18'h0, 1, "R2");
        cyc(1, 1, 2, map_a(495), 32'h8000_0022, 18'h0, 1, "R2");
        cyc(1, 1, 2, 12'h004,    32'hFFFF_FFFF, 18'h0, 1, "R5");
        do_reset();
        cyc(1, 0, 2, map_a(0),   0, 18'h0, 1, "R1");
        cyc(1, 0, 2, map_a(495), 0, {9'd495, 9'd0}, 1, "R1");
        cyc(1, 0, 2, 12'h004,    0, 18'h0, 1, "R1");
        // Masking of map writes (R2)
        cyc(1, 1, 2, map_a(7), 32'hFFFF_FFFF, 18'h0, 1, "R2");
        cyc(1, 0, 2, map_a(7), 0, 18'h0, 1, "R2");
        cyc(1, 1, 2, map_a(8), 32'h7C00_0000, 18'h0, 1, "R2");
        cyc(1, 0, 2, map_a(8), 0, 18'h0, 1, "R2");
        // Out-of-range map offsets (R3)
        cyc(1, 1, 2, map_a(496), 32'h8000_0001, 18'h0, 1, "R3");
        cyc(1, 0, 2, map_a(511), 0, 18'h0, 1, "R3");
        // Configuration register (R4)
        cyc(1, 1, 2, 12'h000, 32'h1234_5678, 18'h0, 1, "R4");
        cyc(1, 0, 2, 12'h000, 0, 18'h0, 1, "R4");
        // Status registers (R5)
        for (int k = 1; k <= 3; k++) begin
            cyc(1, 1, 2, 12'(k * 4), 32'hFFFF_FFFF, 18'h0, 1, "R5");
            cyc(1, 0, 2, 12'(k * 4), 0, 18'h0, 1, "R5");
        end
        // Nonexistent low offsets (R6)
        cyc(1, 0, 2, 12'h010, 0, 18'h0, 1, "R6");
        cyc(1, 1, 2, 12'h7FC, 32'hFFFF_FFFF, 18'h0, 1, "R6");
        // Rejected sizes and alignments (R7)
        cyc(1, 1, 2, map_a(5) + 12'd2, 32'h8000_00AA, 18'h0, 1, "R7");
        cyc(1, 1, 0, map_a(5), 32'h8000_00AA, 18'h0, 1, "R7");
        cyc(1, 1, 1, map_a(5), 32'h8000_00AA, 18'h0, 1, "R7");
        cyc(1, 0, 2, map_a(5), 0, {9'd5, 9'd3}, 1, "R7");
        cyc(1, 0, 3, 12'h000, 0, 18'h0, 1, "R7");
        cyc(0, 0, 2, 12'h000, 0, 18'h0, 1, "R7");
        // Translation arithmetic (R8), odd byte (R9)
        cyc(1, 1, 2, map_a(3), 32'h8012_3456, {9'd3, 9'h1FF}, 1, "R12");
        cyc(0, 0, 2, 0, 0, {9'd3, 9'h1FF}, 1, "R8");
        cyc(1, 1, 2, map_a(4), 32'h8220_0100, {9'd4, 9'h010}, 1, "R12");
        cyc(0, 0, 2, 0, 0, {9'd4, 9'h010}, 1, "R9");
        cyc(1, 1, 2, map_a(6), 32'h8200_0100, {9'd6, 9'h010}, 1, "R9");
        cyc(0, 0, 2, 0, 0, {9'd6, 9'h010}, 1, "R9");
        cyc(1, 1, 2, map_a(9), 32'h83FF_FFFF, {9'd9, 9'h1FF}, 1, "R9");
        cyc(0, 0, 2, 0, 0, {9'd9, 9'h1FF}, 1, "R9");
        // Failed lookups (R10) and memory gate (R11)
        cyc(0, 0, 2, 0, 0, {9'd8, 9'h0}, 1, "R10");
        cyc(0, 0, 2, 0, 0, {9'd500, 9'h0}, 1, "R10");
        cyc(0, 0, 2, 0, 0, {9'd3, 9'h004}, 0, "R11");
        // Same-cycle write and lookup (R12)
        cyc(1, 1, 2, map_a(3), 32'h0000_0000, {9'd3, 9'h020}, 1, "R12");
        cyc(0, 0, 2, 0, 0, {9'd3, 9'h020}, 1, "R12");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op; int k; logic [17:0] ba; logic [11:0] ad; logic [1:0] sz;
            op = int'($urandom % 8);
            k  = int'($urandom % 16);
            ba = ($urandom % 10 == 0) ? {9'(496 + $urandom % 16), 9'($urandom)}
                                      : {9'($urandom % 16), 9'($urandom)};
            sz = 2'd2; ad = map_a(k);
            if (op == 4) ad = 12'(($urandom % 4) * 4);
            if (op == 5) begin ad = map_a(k) + 12'($urandom % 4); sz = 2'($urandom); end
            if (op == 6) ad = 12'((4 + $urandom % 508) * 4);
            if (op == 7) ad = map_a(496 + int'($urandom % 16));
            cyc(1, op != 3, sz, ad, $urandom, ba, ($urandom % 4) != 0, "R12");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule